// File: doc/BRIEF.md
# Pipeline Forwarding and Interlock Unit

This block is the data-hazard controller of an in-order five-stage integer pipeline (fetch, decode, execute, memory, write-back) with 32 general registers. Each cycle it is given the register fields of the instructions in every stage. It returns bypass selects for the two execute operands and for the store data in the memory stage, the stall decisions, a fetch enable and three statistics counters. The operand muxes, register file, ALU and memories sit outside and follow these controls.

A run-time input chooses the hazard policy. With bypassing on, results move from the memory or write-back stage straight into execute. Only a load whose data is still in the memory stage can stall a consumer, and that stall is taken in execute: the consumer and everything younger hold, and a bubble enters the memory stage. With bypassing off, all selects read the register file. A consumer waits in decode while any in-flight instruction in execute, memory or write-back still has to write one of its sources. During that wait a bubble enters execute. A halt seen in fetch stops all later fetching, and the older instructions drain.

The counters count cycles up to and including the cycle in which the halt retires. They also count retired instructions and stall cycles, so cycles per instruction can be worked out after a run.

Top module: `fwd_interlock_unit`

## Requirements
- R1: With bypassing on, an execute source that matches the destination of a writing, non-load instruction in memory gets select 01 (memory bypass), even when write-back also matches.
- R2: With bypassing on, an execute source matched only by a writing instruction in write-back, or whose memory-stage match is a load, gets select 10 (write-back bypass) if write-back matches, else 00 (register file).
- R3: With bypassing on, an execute source matched by a load in memory raises stall_ex, holds decode (hold_id high) and drops fetch_go in that same cycle.
- R4: The store-data source (execute source B while ex_store is high) never causes an execute stall. In the memory stage, fwd_st is high when bypassing is on and a writing instruction in write-back has mem_src_b as its destination (mem_src_b nonzero).
- R5: Register 0, an invalid stage, a stage with its write flag low, or an operand whose use flag is low never produces a match, a bypass or a stall.
- R6: With bypassing off, all selects are 00, fwd_st and stall_ex stay low, and stall_id is high while a used nonzero decode source equals the destination of a valid, writing instruction in execute, memory or write-back.
- R7: stall_reg gives the index of the source that caused the current stall, choosing source A when both sources stall, and is 0 when no stall is raised.
- R8: fetch_go is low in any cycle with a valid halt in fetch. From the next cycle until reset, halted is high and fetch_go stays low.
- R9: Counting from the first cycle after reset, cnt_cycles counts every cycle up to and including the one in which a halt is in write-back. cnt_instr counts valid write-back cycles and cnt_stalls counts stall cycles; all three freeze after that. A five-instruction load/load/add/store/halt program with one load-use dependence gives 10/5/1 with bypassing and 15/5/6 without.
- R10: After reset the counters and halted are 0, and with idle stages all selects and stalls are low and fetch_go is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fwd_en | input | 1 | 1 = bypassing on, 0 = interlock in decode |
| if_valid | input | 1 | Fetch stage holds an instruction |
| if_halt | input | 1 | Fetched instruction is a halt |
| id_valid | input | 1 | Decode stage holds an instruction |
| id_src_a | input | 5 | Decode source A index |
| id_src_b | input | 5 | Decode source B index |
| id_use_a | input | 1 | Decode instruction reads source A |
| id_use_b | input | 1 | Decode instruction reads source B |
| ex_valid | input | 1 | Execute stage holds an instruction |
| ex_src_a | input | 5 | Execute source A index |
| ex_src_b | input | 5 | Execute source B index |
| ex_use_a | input | 1 | Execute instruction reads source A |
| ex_use_b | input | 1 | Execute instruction reads source B |
| ex_store | input | 1 | Execute source B is store data |
| ex_dst | input | 5 | Execute destination index |
| ex_wr | input | 1 | Execute instruction writes a register |
| mem_valid | input | 1 | Memory stage holds an instruction |
| mem_dst | input | 5 | Memory destination index |
| mem_wr | input | 1 | Memory instruction writes a register |
| mem_load | input | 1 | Memory instruction is a load |
| mem_store | input | 1 | Memory instruction is a store |
| mem_src_b | input | 5 | Store-data register of the memory instruction |
| wb_valid | input | 1 | Write-back stage holds an instruction |
| wb_dst | input | 5 | Write-back destination index |
| wb_wr | input | 1 | Write-back instruction writes a register |
| wb_halt | input | 1 | Write-back instruction is a halt |
| fwd_a | output | 2 | Execute operand A select: 00 file, 01 memory, 10 write-back |
| fwd_b | output | 2 | Execute operand B select, same coding |
| fwd_st | output | 1 | Store data in memory stage taken from write-back |
| stall_ex | output | 1 | Execute holds, bubble into memory |
| stall_id | output | 1 | Decode holds, bubble into execute |
| stall_reg | output | 5 | Register index behind the current stall |
| hold_id | output | 1 | Fetch and decode registers hold |
| fetch_go | output | 1 | Fetch may take a new instruction |
| halted | output | 1 | A halt has been fetched |
| cnt_cycles | output | 32 | Cycle count |
| cnt_instr | output | 32 | Retired instruction count |
| cnt_stalls | output | 32 | Stall cycle count |

## Verification
On every cycle, the assertions check these rules: register 0 and bypass-off mode never bypass or stall in execute, the two stall kinds never coincide, a stall always holds decode and fetch, stall_reg agrees with the stall, halt is sticky and freezes fetch, and the cycle counter steps by one until it freezes. Only the bench scenarios can show that the select codes and the stall cycle are right for a given set of stage contents. The bench sweeps every combination over a three-register subset. It also runs a small program through a bench-side pipeline model that follows the block's hold and fetch outputs, which shows the end-to-end cycle, retire and stall totals in both modes.

// File: rtl/fiu_pkg.sv
package fiu_pkg;
  typedef enum logic [1:0] {
    FW_RF  = 2'd0,
    FW_MEM = 2'd1,
    FW_WB  = 2'd2
  } fwd_sel_e;
endpackage

// File: rtl/fiu_ex_match.sv
module fiu_ex_match
  import fiu_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fwd_en_i,
  input  logic             need_i,
  input  logic [REG_W-1:0] src_i,
  input  logic             late_ok_i,
  input  logic             mem_valid_i,
  input  logic             mem_wr_i,
  input  logic             mem_load_i,
  input  logic [REG_W-1:0] mem_dst_i,
  input  logic             wb_valid_i,
  input  logic             wb_wr_i,
  input  logic [REG_W-1:0] wb_dst_i,
  output fwd_sel_e         sel_o,
  output logic             stall_o
);
  logic live, mem_hit, wb_hit;

  assign live    = need_i && (src_i != '0);
  assign mem_hit = live && mem_valid_i && mem_wr_i && (mem_dst_i == src_i);
  assign wb_hit  = live && wb_valid_i && wb_wr_i && (wb_dst_i == src_i);

  always_comb begin
    sel_o   = FW_RF;
    stall_o = 1'b0;
    if (fwd_en_i) begin
      if (mem_hit && !mem_load_i) sel_o = FW_MEM;
      else if (wb_hit)            sel_o = FW_WB;
      if (mem_hit && mem_load_i && !late_ok_i) stall_o = 1'b1;
    end
  end

  // R5: the zero register never bypasses or stalls
  p_zero_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (src_i == '0) |-> (sel_o == FW_RF && !stall_o));
  // R6: bypass-off mode leaves execute alone
  p_off_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !fwd_en_i |-> (sel_o == FW_RF && !stall_o));
endmodule

// File: rtl/fiu_id_check.sv
module fiu_id_check #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chk_i,
  input  logic [REG_W-1:0] src_i,
  input  logic             ex_valid_i,
  input  logic             ex_wr_i,
  input  logic [REG_W-1:0] ex_dst_i,
  input  logic             mem_valid_i,
  input  logic             mem_wr_i,
  input  logic [REG_W-1:0] mem_dst_i,
  input  logic             wb_valid_i,
  input  logic             wb_wr_i,
  input  logic [REG_W-1:0] wb_dst_i,
  output logic             hit_o
);
  logic in_ex, in_mem, in_wb;

  assign in_ex  = ex_valid_i  && ex_wr_i  && (ex_dst_i  == src_i);
  assign in_mem = mem_valid_i && mem_wr_i && (mem_dst_i == src_i);
  assign in_wb  = wb_valid_i  && wb_wr_i  && (wb_dst_i  == src_i);
  assign hit_o  = chk_i && (src_i != '0) && (in_ex || in_mem || in_wb);

  // R5: a decode read of register 0 never waits
  p_id_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (src_i == '0) |-> !hit_o);
endmodule

// File: rtl/fiu_stats.sv
module fiu_stats #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             retire_i,
  input  logic             stall_i,
  input  logic             halt_retire_i,
  output logic [CNT_W-1:0] cycles_o,
  output logic [CNT_W-1:0] instr_o,
  output logic [CNT_W-1:0] stalls_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q   <= 1'b0;
      cycles_o <= '0;
      instr_o  <= '0;
      stalls_o <= '0;
    end else if (!done_q) begin
      cycles_o <= cycles_o + ONE;
      if (retire_i)      instr_o  <= instr_o + ONE;
      if (stall_i)       stalls_o <= stalls_o + ONE;
      if (halt_retire_i) done_q   <= 1'b1;
    end
  end

  // R9: one count per cycle until the halt retires, then frozen
  p_cycle_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |=> (cycles_o == $past(cycles_o) + ONE));
  p_cycle_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> ($stable(cycles_o) && $stable(instr_o) && $stable(stalls_o)));
endmodule

// File: rtl/fwd_interlock_unit.sv
module fwd_interlock_unit
  import fiu_pkg::*;
#(
  parameter int REG_W = 5,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fwd_en,
  input  logic             if_valid,
  input  logic             if_halt,
  input  logic             id_valid,
  input  logic [REG_W-1:0] id_src_a,
  input  logic [REG_W-1:0] id_src_b,
  input  logic             id_use_a,
  input  logic             id_use_b,
  input  logic             ex_valid,
  input  logic [REG_W-1:0] ex_src_a,
  input  logic [REG_W-1:0] ex_src_b,
  input  logic             ex_use_a,
  input  logic             ex_use_b,
  input  logic             ex_store,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             ex_wr,
  input  logic             mem_valid,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_wr,
  input  logic             mem_load,
  input  logic             mem_store,
  input  logic [REG_W-1:0] mem_src_b,
  input  logic             wb_valid,
  input  logic [REG_W-1:0] wb_dst,
  input  logic             wb_wr,
  input  logic             wb_halt,
  output logic [1:0]       fwd_a,
  output logic [1:0]       fwd_b,
  output logic             fwd_st,
  output logic             stall_ex,
  output logic             stall_id,
  output logic [REG_W-1:0] stall_reg,
  output logic             hold_id,
  output logic             fetch_go,
  output logic             halted,
  output logic [CNT_W-1:0] cnt_cycles,
  output logic [CNT_W-1:0] cnt_instr,
  output logic [CNT_W-1:0] cnt_stalls
);
  localparam int NSRC = 2;

  logic [NSRC-1:0][REG_W-1:0] ex_src, id_src;
  logic [NSRC-1:0]            ex_need, ex_late, id_need, ex_stl, id_hit;
  fwd_sel_e                   ex_sel [NSRC];
  logic                       halted_q, halt_in_if, stall_any;

  assign ex_src  = {ex_src_b, ex_src_a};
  assign id_src  = {id_src_b, id_src_a};
  assign ex_need = {ex_valid & ex_use_b, ex_valid & ex_use_a};
  assign ex_late = {ex_store, 1'b0};
  assign id_need = {id_valid & id_use_b, id_valid & id_use_a};

  for (genvar gi = 0; gi < NSRC; gi++) begin : g_src
    fiu_ex_match #(.REG_W(REG_W)) u_exm (
      .clk        (clk),
      .rst_n      (rst_n),
      .fwd_en_i   (fwd_en),
      .need_i     (ex_need[gi]),
      .src_i      (ex_src[gi]),
      .late_ok_i  (ex_late[gi]),
      .mem_valid_i(mem_valid),
      .mem_wr_i   (mem_wr),
      .mem_load_i (mem_load),
      .mem_dst_i  (mem_dst),
      .wb_valid_i (wb_valid),
      .wb_wr_i    (wb_wr),
      .wb_dst_i   (wb_dst),
      .sel_o      (ex_sel[gi]),
      .stall_o    (ex_stl[gi])
    );
    fiu_id_check #(.REG_W(REG_W)) u_idc (
      .clk        (clk),
      .rst_n      (rst_n),
      .chk_i      (!fwd_en && id_need[gi]),
      .src_i      (id_src[gi]),
      .ex_valid_i (ex_valid),
      .ex_wr_i    (ex_wr),
      .ex_dst_i   (ex_dst),
      .mem_valid_i(mem_valid),
      .mem_wr_i   (mem_wr),
      .mem_dst_i  (mem_dst),
      .wb_valid_i (wb_valid),
      .wb_wr_i    (wb_wr),
      .wb_dst_i   (wb_dst),
      .hit_o      (id_hit[gi])
    );
  end

  assign fwd_a    = ex_sel[0];
  assign fwd_b    = ex_sel[1];
  assign stall_ex = |ex_stl;
  assign stall_id = |id_hit;
  assign fwd_st   = fwd_en && mem_valid && mem_store && (mem_src_b != '0) &&
                    wb_valid && wb_wr && (wb_dst == mem_src_b);

  always_comb begin
    stall_reg = '0;
    if (stall_ex)      stall_reg = ex_stl[0] ? ex_src[0] : ex_src[1];
    else if (stall_id) stall_reg = id_hit[0] ? id_src[0] : id_src[1];
  end

  assign stall_any  = stall_ex | stall_id;
  assign hold_id    = stall_any;
  assign halt_in_if = if_valid & if_halt;
  assign fetch_go   = !hold_id && !halted_q && !halt_in_if;
  assign halted     = halted_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          halted_q <= 1'b0;
    else if (halt_in_if) halted_q <= 1'b1;
  end

  fiu_stats #(.CNT_W(CNT_W)) u_stats (
    .clk          (clk),
    .rst_n        (rst_n),
    .retire_i     (wb_valid),
    .stall_i      (stall_any),
    .halt_retire_i(wb_valid & wb_halt),
    .cycles_o     (cnt_cycles),
    .instr_o      (cnt_instr),
    .stalls_o     (cnt_stalls)
  );

  // R6: the two stall locations are never active together
  p_one_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(stall_ex && stall_id));
  // R3: a stall freezes decode and fetch in the same cycle
  p_stall_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stall_any |-> (hold_id && !fetch_go));
  // R7: the reported index agrees with the stall state
  p_stall_idx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall_any |-> (stall_reg != '0));
  p_stall_idx0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !stall_any |-> (stall_reg == '0));
  // R8: a fetched halt stays in force and keeps fetch off
  p_halt_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
  p_halt_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !fetch_go);
endmodule

// File: tb/sim_fwd_interlock_unit.sv
module sim_fwd_interlock_unit;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, fwd_en, if_valid, if_halt, id_valid, id_use_a, id_use_b;
  logic [4:0] id_src_a, id_src_b, ex_src_a, ex_src_b, ex_dst, mem_dst, mem_src_b, wb_dst;
  logic ex_valid, ex_use_a, ex_use_b, ex_store, ex_wr;
  logic mem_valid, mem_wr, mem_load, mem_store, wb_valid, wb_wr, wb_halt;
  logic [1:0] fwd_a, fwd_b;
  logic fwd_st, stall_ex, stall_id, hold_id, fetch_go, halted;
  logic [4:0] stall_reg;
  logic [31:0] cnt_cycles, cnt_instr, cnt_stalls;

  fwd_interlock_unit u0 (.*);

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  task automatic idle();
    if_valid = 0; if_halt = 0; id_valid = 0; id_use_a = 0; id_use_b = 0;
    id_src_a = 0; id_src_b = 0; ex_valid = 0; ex_src_a = 0; ex_src_b = 0;
    ex_use_a = 0; ex_use_b = 0; ex_store = 0; ex_dst = 0; ex_wr = 0;
    mem_valid = 0; mem_dst = 0; mem_wr = 0; mem_load = 0; mem_store = 0;
    mem_src_b = 0; wb_valid = 0; wb_dst = 0; wb_wr = 0; wb_halt = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; idle();
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  // program: ld r4 / ld r5 / add r3,r4,r5 / store r3 / halt
  int p_dst[5] = '{4, 5, 3, 0, 0};
  int p_sa [5] = '{0, 0, 4, 0, 0};
  int p_sb [5] = '{0, 0, 5, 3, 0};
  bit p_ua [5] = '{1, 1, 1, 1, 0};
  bit p_ub [5] = '{0, 0, 1, 1, 0};
  bit p_wr [5] = '{1, 1, 1, 0, 0};
  bit p_ld [5] = '{1, 1, 0, 0, 0};
  bit p_st [5] = '{0, 0, 0, 1, 0};
  bit p_ht [5] = '{0, 0, 0, 0, 1};

  int s_if, s_id, s_ex, s_mem, s_wb, pc;
  bit r_sx[32], r_si[32], r_fs[32];
  int r_reg[32], r_fa[32], r_fb[32];

  task automatic drive_stages();
    if_valid = s_if >= 0;  if_halt = s_if >= 0 ? p_ht[s_if] : 0;
    id_valid = s_id >= 0;
    id_src_a = s_id >= 0 ? 5'(p_sa[s_id]) : 0; id_src_b = s_id >= 0 ? 5'(p_sb[s_id]) : 0;
    id_use_a = s_id >= 0 ? p_ua[s_id] : 0;     id_use_b = s_id >= 0 ? p_ub[s_id] : 0;
    ex_valid = s_ex >= 0;
    ex_src_a = s_ex >= 0 ? 5'(p_sa[s_ex]) : 0; ex_src_b = s_ex >= 0 ? 5'(p_sb[s_ex]) : 0;
    ex_use_a = s_ex >= 0 ? p_ua[s_ex] : 0;     ex_use_b = s_ex >= 0 ? p_ub[s_ex] : 0;
    ex_store = s_ex >= 0 ? p_st[s_ex] : 0;
    ex_dst   = s_ex >= 0 ? 5'(p_dst[s_ex]) : 0; ex_wr = s_ex >= 0 ? p_wr[s_ex] : 0;
    mem_valid = s_mem >= 0;
    mem_dst   = s_mem >= 0 ? 5'(p_dst[s_mem]) : 0; mem_wr = s_mem >= 0 ? p_wr[s_mem] : 0;
    mem_load  = s_mem >= 0 ? p_ld[s_mem] : 0;     mem_store = s_mem >= 0 ? p_st[s_mem] : 0;
    mem_src_b = s_mem >= 0 ? 5'(p_sb[s_mem]) : 0;
    wb_valid = s_wb >= 0;
    wb_dst   = s_wb >= 0 ? 5'(p_dst[s_wb]) : 0; wb_wr = s_wb >= 0 ? p_wr[s_wb] : 0;
    wb_halt  = s_wb >= 0 ? p_ht[s_wb] : 0;
  endtask

  task automatic run_prog(input bit fe);
    do_reset();
    fwd_en = fe;
    s_if = 0; pc = 1; s_id = -1; s_ex = -1; s_mem = -1; s_wb = -1;
    for (int cyc = 1; cyc <= 24; cyc++) begin
      bit sx, sid, hid, fg;
      drive_stages();
      #5;
      sx = stall_ex; sid = stall_id; hid = hold_id; fg = fetch_go;
      r_sx[cyc] = sx; r_si[cyc] = sid; r_reg[cyc] = stall_reg;
      r_fa[cyc] = fwd_a; r_fb[cyc] = fwd_b; r_fs[cyc] = fwd_st;
      @(negedge clk);
      s_wb  = s_mem;
      s_mem = sx ? -1 : s_ex;
      if (!sx) s_ex = sid ? -1 : s_id;
      if (!hid) begin
        s_id = s_if;
        if (fg && pc < 5) begin s_if = pc; pc++; end
        else s_if = -1;
      end
    end
  endtask

  initial begin
    fwd_en = 1;
    do_reset();
    #5;
    // R10: reset state
    chk(cnt_cycles == 0 && cnt_instr == 0 && cnt_stalls == 0, "R10 counters", cnt_cycles, 0);
    chk(halted == 0 && fetch_go == 1, "R10 halted/fetch_go", {halted, fetch_go}, 2'b01);
    chk(fwd_a == 0 && fwd_b == 0 && !fwd_st && !stall_ex && !stall_id && stall_reg == 0,
        "R10 selects idle", {fwd_a, fwd_b, stall_ex, stall_id}, 0);

    // Sweep 1: execute operand A over registers 0..2 (R1 R2 R3 R5 R6 R7)
    for (int fe = 0; fe < 2; fe++)
     for (int ua = 0; ua < 2; ua++)
      for (int sa = 0; sa < 3; sa++)
       for (int mv = 0; mv < 2; mv++)
        for (int md = 0; md < 3; md++)
         for (int mw = 0; mw < 2; mw++)
          for (int ml = 0; ml < 2; ml++)
           for (int wd = 0; wd < 3; wd++)
            for (int ww = 0; ww < 2; ww++) begin
              bit m, w, es; int esel, ereg; string tag;
              @(negedge clk);
              idle();
              fwd_en = fe[0]; ex_valid = 1; ex_use_a = ua[0]; ex_src_a = 5'(sa);
              mem_valid = mv[0]; mem_dst = 5'(md); mem_wr = mw[0]; mem_load = ml[0];
              wb_valid = 1; wb_dst = 5'(wd); wb_wr = ww[0];
              m = fe && ua && sa != 0 && mv && mw && md == sa;
              w = fe && ua && sa != 0 && ww && wd == sa;
              es = m && ml;
              esel = (m && !ml) ? 1 : (w ? 2 : 0);
              ereg = es ? sa : 0;
              tag = es ? "R3 load stall" : esel == 1 ? "R1 mem bypass" :
                    esel == 2 ? "R2 wb bypass" : fe ? "R5 no match" : "R6 bypass off";
              #5;
              chk(fwd_a == esel && stall_ex == es && stall_reg == ereg && fetch_go == !es
                  && hold_id == es, tag,
                  {fwd_a, stall_ex, stall_reg, fetch_go}, {2'(esel), es, 5'(ereg), !es});
            end

    // Sweep 2: decode interlock with bypassing off (R6 R5 R7)
    for (int fe = 0; fe < 2; fe++)
     for (int ia = 0; ia < 3; ia++)
      for (int ed = 0; ed < 3; ed++)
       for (int md = 0; md < 3; md++)
        for (int wd = 0; wd < 3; wd++) begin
          bit h;
          @(negedge clk);
          idle();
          fwd_en = fe[0]; id_valid = 1; id_use_a = 1; id_src_a = 5'(ia);
          ex_valid = 1; ex_wr = 1; ex_dst = 5'(ed);
          mem_valid = 1; mem_wr = 1; mem_dst = 5'(md);
          wb_valid = 1; wb_wr = 1; wb_dst = 5'(wd);
          h = !fe && ia != 0 && (ed == ia || md == ia || wd == ia);
          #5;
          chk(stall_id == h && !stall_ex && stall_reg == (h ? ia : 0) && fetch_go == !h,
              "R6 decode interlock", {stall_id, stall_reg}, {h, 5'(h ? ia : 0)});
        end

    // Sweep 3: store data bypass in memory stage (R4)
    for (int fe = 0; fe < 2; fe++)
     for (int sb = 0; sb < 3; sb++)
      for (int wd = 0; wd < 3; wd++)
       for (int ww = 0; ww < 2; ww++) begin
         bit e;
         @(negedge clk);
         idle();
         fwd_en = fe[0]; mem_valid = 1; mem_store = 1; mem_src_b = 5'(sb);
         wb_valid = 1; wb_dst = 5'(wd); wb_wr = ww[0];
         e = fe && sb != 0 && ww && wd == sb;
         #5;
         chk(fwd_st == e, "R4 store bypass", fwd_st, e);
       end

    // R4: store data source matched by a load does not stall
    @(negedge clk); idle(); fwd_en = 1;
    ex_valid = 1; ex_use_b = 1; ex_store = 1; ex_src_b = 2;
    mem_valid = 1; mem_wr = 1; mem_load = 1; mem_dst = 2;
    #5;
    chk(!stall_ex && fwd_b == 0 && fetch_go, "R4 no store stall", {stall_ex, fwd_b}, 0);
    // R3/R7: source B load stall reports its index
    @(negedge clk); ex_store = 0; ex_src_b = 6; mem_dst = 6;
    #5;
    chk(stall_ex && stall_reg == 6, "R7 source B index", stall_reg, 6);
    // R7: both decode sources wait, A reported
    @(negedge clk); idle(); fwd_en = 0;
    id_valid = 1; id_use_a = 1; id_use_b = 1; id_src_a = 1; id_src_b = 2;
    ex_valid = 1; ex_wr = 1; ex_dst = 2; mem_valid = 1; mem_wr = 1; mem_dst = 1;
    #5;
    chk(stall_id && stall_reg == 1, "R7 source A first", stall_reg, 1);

    // R8: halt in fetch
    do_reset(); fwd_en = 1;
    if_valid = 1; if_halt = 1;
    #5;
    chk(!fetch_go && !halted, "R8 halt in fetch", {fetch_go, halted}, 0);
    @(negedge clk); if_valid = 0; if_halt = 0;
    #5;
    chk(!fetch_go && halted, "R8 halted after", {fetch_go, halted}, 1);
    repeat (3) @(negedge clk);
    #5;
    chk(!fetch_go && halted, "R8 stays halted", {fetch_go, halted}, 1);
    do_reset();
    #5;
    chk(!halted && fetch_go, "R10 halt cleared by reset", halted, 0);

    // Program with bypassing
    run_prog(1);
    chk(r_sx[5] && r_reg[5] == 5, "R3 load-use in execute", r_reg[5], 5);
    chk(r_fa[5] == 2, "R2 r4 from write-back", r_fa[5], 2);
    chk(r_fb[6] == 2 && !r_sx[6], "R2 r5 after stall", r_fb[6], 2);
    chk(r_fb[7] == 1, "R1 store data from memory", r_fb[7], 1);
    chk(r_fs[8], "R4 store data at memory", r_fs[8], 1);
    chk(cnt_cycles == 10, "R9 cycles bypass on", cnt_cycles, 10);
    chk(cnt_instr == 5, "R9 instr bypass on", cnt_instr, 5);
    chk(cnt_stalls == 1, "R9 stalls bypass on", cnt_stalls, 1);

    // Program without bypassing
    run_prog(0);
    chk(r_si[4] && r_reg[4] == 4, "R6 decode wait r4", r_reg[4], 4);
    chk(r_si[8] && r_reg[8] == 3, "R6 decode wait r3", r_reg[8], 3);
    chk(!r_si[11], "R6 released after write-back", r_si[11], 0);
    chk(cnt_cycles == 15, "R9 cycles bypass off", cnt_cycles, 15);
    chk(cnt_instr == 5, "R9 instr bypass off", cnt_instr, 5);
    chk(cnt_stalls == 6, "R9 stalls bypass off", cnt_stalls, 6);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule